// File: doc/BRIEF.md
# Timeout Dynamic Power Manager

This block controls the supply state of a single service device that can be powered or unpowered. Service requests arrive as one-cycle pulses and are held in a small saturating backlog counter. While the device is powered, it drains one request per time tick. A run-time selectable policy decides when the device is brought up and when it is shut down: it can be held powered permanently, shut down the moment work runs out, or shut down after a programmable number of idle ticks. Bring-up and shut-down are multi-tick phases with unequal length and cost, and neither phase is ever abandoned once begun.

Time advances only on clock cycles where the tick enable is high. On every tick the block also updates two saturating figures of merit. The first is an energy total, which charges each tick by the phase the device is in. The second is a latency total, which adds the current backlog and so sums request-ticks of waiting. Software can run a workload under each policy and compare the two totals directly.

Top module: `idle_power_mgr`

## Requirements
- R1: While synchronous active-high reset is asserted, the device state is Off, and the backlog, energy total and latency total are all zero.
- R2: The device state is reported as 0 for Off, 1 for Waking, 2 for On and 3 for Sleeping, and it changes only at clock edges where tick is high. Waking lasts 2 ticks and Sleeping lasts 1 tick, and `dev_powered` is high exactly in state 2.
- R3: A req pulse raises the backlog by one on any clock cycle, saturating at 2^CNT_W-1. On each tick in state On with a non-zero backlog, one request is served and the backlog drops by one. A request and a service at the same edge leave the backlog unchanged.
- R4: With policy 0 (always powered), an Off device starts Waking on the next tick, and an On device never leaves On.
- R5: With policy 1 (greedy), an Off device starts Waking on a tick when the backlog is non-zero. An On device starts Sleeping on a tick when the backlog is zero and no req arrives in that cycle.
- R6: With policy 2 or 3 (timeout), an On device counts idle ticks, meaning ticks with a zero backlog and no req. It starts Sleeping on the idle tick at which the count already equals idle_limit. Any req or pending work clears the count, and a limit of 0 behaves like the greedy policy.
- R7: A request that arrives while Sleeping does not abort the shutdown. When Sleeping ends with a non-zero backlog, or under policy 0, the device goes straight to Waking without passing through Off.
- R8: On each tick the energy total grows by the cost of the state held during that tick: 0 for Off, 20 for each Waking tick (40 per bring-up), 10 for On and 10 for Sleeping. The total saturates at its maximum value.
- R9: On each tick the latency total grows by the backlog held before that edge, saturating at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable; one tick per high cycle |
| req | input | 1 | Service request pulse |
| policy | input | 2 | 0 always powered, 1 greedy, 2 or 3 timeout |
| idle_limit | input | TO_W | Idle ticks tolerated before shutdown under timeout |
| dev_state | output | 2 | 0 Off, 1 Waking, 2 On, 3 Sleeping |
| dev_powered | output | 1 | High while the device is On |
| backlog | output | CNT_W | Pending request count |
| energy_acc | output | EN_W | Saturating energy total |
| latency_acc | output | LAT_W | Saturating request-tick total |

## Verification
The delicate coincidence is a request pulse landing on the same tick edge where the device serves a request or would let its idle count expire. In that cycle, the backlog must hold steady and the shutdown decision must be cancelled. Dense pseudo-random request streams with ticks present on three cycles in four, swept over every policy and several idle limits, produce these collisions repeatedly. A lockstep arithmetic model derived from the requirements judges state, backlog and both totals after every edge. Short directed sequences pin down the exact bring-up cost, the idle-count boundary, and the Sleeping-to-Waking shortcut.

// File: rtl/idle_pm_pkg.sv
package idle_pm_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_WAKE  = 2'd1,
        PS_ON    = 2'd2,
        PS_SLEEP = 2'd3
    } pwr_state_t;

    typedef enum logic [1:0] {
        POL_ALWAYS  = 2'd0,
        POL_GREEDY  = 2'd1,
        POL_TIMEOUT = 2'd2
    } policy_t;

    // Code 3 is folded onto the timeout policy.
    function automatic policy_t decode_policy(input logic [1:0] raw);
        case (raw)
            2'd0:    return POL_ALWAYS;
            2'd1:    return POL_GREEDY;
            default: return POL_TIMEOUT;
        endcase
    endfunction

endpackage

// File: rtl/ipm_backlog.sv
module ipm_backlog #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             serve,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (req && !serve) begin
            if (count != CNT_MAX) count <= count + 1'b1;
        end else if (serve && !req) begin
            count <= count - 1'b1;
        end
    end

    // R3: backlog moves by at most one per edge
    p_backlog_step_r3: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |->
            (count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

    // R3: saturation holds the maximum
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX && req && !serve) |=> (count == CNT_MAX));

endmodule

// File: rtl/ipm_fsm.sv
module ipm_fsm
    import idle_pm_pkg::*;
#(
    parameter int TO_W        = 8,
    parameter int WAKE_TICKS  = 2,
    parameter int SLEEP_TICKS = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            req,
    input  logic            has_work,
    input  logic [1:0]      policy_raw,
    input  logic [TO_W-1:0] idle_limit,
    output pwr_state_t      state,
    output logic            serve
);
    localparam int PH_MAX = (WAKE_TICKS > SLEEP_TICKS) ? WAKE_TICKS : SLEEP_TICKS;
    localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
    localparam logic [PH_W-1:0] WAKE_LAST  = PH_W'(WAKE_TICKS - 1);
    localparam logic [PH_W-1:0] SLEEP_LAST = PH_W'(SLEEP_TICKS - 1);

    policy_t         pol;
    logic [PH_W-1:0] phase;
    logic [TO_W-1:0] idle_cnt;
    logic            idle_now;

    assign pol      = decode_policy(policy_raw);
    assign idle_now = !has_work && !req;
    assign serve    = tick && (state == PS_ON) && has_work;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_OFF;
            phase    <= '0;
            idle_cnt <= '0;
        end else if (tick) begin
            case (state)
                PS_OFF: begin
                    phase <= '0;
                    if (pol == POL_ALWAYS || has_work) state <= PS_WAKE;
                end
                PS_WAKE: begin
                    if (phase == WAKE_LAST) begin
                        state    <= PS_ON;
                        phase    <= '0;
                        idle_cnt <= '0;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                PS_ON: begin
                    if (!idle_now) begin
                        idle_cnt <= '0;
                    end else if (pol != POL_ALWAYS) begin
                        if (pol == POL_GREEDY || idle_cnt == idle_limit) begin
                            state    <= PS_SLEEP;
                            phase    <= '0;
                            idle_cnt <= '0;
                        end else begin
                            idle_cnt <= idle_cnt + 1'b1;
                        end
                    end
                end
                PS_SLEEP: begin
                    if (phase == SLEEP_LAST) begin
                        phase <= '0;
                        state <= (pol == POL_ALWAYS || has_work) ? PS_WAKE : PS_OFF;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= PS_OFF;
            endcase
        end
    end

    // R2: no movement without a tick
    p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state));

    // R2: On is entered only from Waking or On
    p_on_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ON) |-> ($past(state) == PS_ON || $past(state) == PS_WAKE));

    // R2: Off is entered only from Off or Sleeping
    p_off_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (state == PS_OFF) |-> ($past(state) == PS_OFF || $past(state) == PS_SLEEP));

    // R4: always-powered policy never leaves On
    p_always_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ON && pol == POL_ALWAYS) |=> (state == PS_ON));

    // R7: pending work at the end of shutdown goes straight to Waking
    p_sleep_rewake_r7: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SLEEP && tick && phase == SLEEP_LAST && has_work) |=> (state == PS_WAKE));

endmodule

// File: rtl/ipm_meter.sv
module ipm_meter
    import idle_pm_pkg::*;
#(
    parameter int EN_W       = 32,
    parameter int LAT_W      = 32,
    parameter int CNT_W      = 4,
    parameter int COST_WAKE  = 20,
    parameter int COST_ON    = 10,
    parameter int COST_SLEEP = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  pwr_state_t       state,
    input  logic [CNT_W-1:0] backlog,
    output logic [EN_W-1:0]  energy,
    output logic [LAT_W-1:0] latency
);
    logic [EN_W:0]  en_sum;
    logic [LAT_W:0] lat_sum;
    logic [EN_W:0]  step;

    always_comb begin
        case (state)
            PS_WAKE:  step = (EN_W+1)'(COST_WAKE);
            PS_ON:    step = (EN_W+1)'(COST_ON);
            PS_SLEEP: step = (EN_W+1)'(COST_SLEEP);
            default:  step = '0;
        endcase
        en_sum  = {1'b0, energy} + step;
        lat_sum = {1'b0, latency} + (LAT_W+1)'(backlog);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            energy  <= '0;
            latency <= '0;
        end else if (tick) begin
            energy  <= en_sum[EN_W]   ? {EN_W{1'b1}}  : en_sum[EN_W-1:0];
            latency <= lat_sum[LAT_W] ? {LAT_W{1'b1}} : lat_sum[LAT_W-1:0];
        end
    end

    // R8: energy never falls
    p_energy_mono_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (energy >= $past(energy)));

    // R9: latency frozen between ticks
    p_lat_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(latency) && $stable(energy)));

    // R8: a powered tick always costs something unless saturated
    p_on_cost_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && state == PS_ON && energy != {EN_W{1'b1}}) |=> (energy > $past(energy)));

endmodule

// File: rtl/idle_power_mgr.sv
module idle_power_mgr
    import idle_pm_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int TO_W         = 8,
    parameter int EN_W         = 32,
    parameter int LAT_W        = 32,
    parameter int ON_POWER     = 10,
    parameter int WAKE_TICKS   = 2,
    parameter int WAKE_ENERGY  = 40,
    parameter int SLEEP_TICKS  = 1,
    parameter int SLEEP_ENERGY = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             req,
    input  logic [1:0]       policy,
    input  logic [TO_W-1:0]  idle_limit,
    output logic [1:0]       dev_state,
    output logic             dev_powered,
    output logic [CNT_W-1:0] backlog,
    output logic [EN_W-1:0]  energy_acc,
    output logic [LAT_W-1:0] latency_acc
);
    localparam int WAKE_PER_TICK  = WAKE_ENERGY / WAKE_TICKS;
    localparam int SLEEP_PER_TICK = SLEEP_ENERGY / SLEEP_TICKS;

    pwr_state_t st;
    logic       serve;
    logic       has_work;

    assign has_work    = (backlog != '0);
    assign dev_state   = st;
    assign dev_powered = (st == PS_ON);

    ipm_backlog #(.CNT_W(CNT_W)) u_backlog (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .serve (serve),
        .count (backlog)
    );

    ipm_fsm #(
        .TO_W        (TO_W),
        .WAKE_TICKS  (WAKE_TICKS),
        .SLEEP_TICKS (SLEEP_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .req        (req),
        .has_work   (has_work),
        .policy_raw (policy),
        .idle_limit (idle_limit),
        .state      (st),
        .serve      (serve)
    );

    ipm_meter #(
        .EN_W       (EN_W),
        .LAT_W      (LAT_W),
        .CNT_W      (CNT_W),
        .COST_WAKE  (WAKE_PER_TICK),
        .COST_ON    (ON_POWER),
        .COST_SLEEP (SLEEP_PER_TICK)
    ) u_meter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .state   (st),
        .backlog (backlog),
        .energy  (energy_acc),
        .latency (latency_acc)
    );

    // R1: reset leaves everything cleared on the following cycle
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dev_state == 2'd0 && backlog == '0 && energy_acc == '0 && latency_acc == '0));

endmodule

// File: tb/tb_idle_power_mgr.sv
module tb_idle_power_mgr;
    localparam int CNT_W = 3;
    localparam int TO_W  = 4;
    localparam int EN_W  = 10;
    localparam int LAT_W = 8;
    localparam int PMAX  = 7;
    localparam int EMAX  = 1023;
    localparam int LMAX  = 255;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic             req = 1'b0;
    logic [1:0]       policy = 2'd0;
    logic [TO_W-1:0]  idle_limit = '0;
    logic [1:0]       dev_state;
    logic             dev_powered;
    logic [CNT_W-1:0] backlog;
    logic [EN_W-1:0]  energy_acc;
    logic [LAT_W-1:0] latency_acc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_st, m_pend, m_idle, m_ph, m_en, m_lat;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    idle_power_mgr #(
        .CNT_W(CNT_W), .TO_W(TO_W), .EN_W(EN_W), .LAT_W(LAT_W)
    ) dut (
        .clk(clk), .rst(rst), .tick(tick), .req(req), .policy(policy),
        .idle_limit(idle_limit), .dev_state(dev_state), .dev_powered(dev_powered),
        .backlog(backlog), .energy_acc(energy_acc), .latency_acc(latency_acc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int cost(input int s);
        case (s)
            1: return 20;
            2: return 10;
            3: return 10;
            default: return 0;
        endcase
    endfunction

    task automatic compare_all();
        chk(int'(dev_state) == m_st, "R2 state", int'(dev_state), m_st);
        chk(dev_powered == (m_st == 2), "R2 powered", int'(dev_powered), int'(m_st == 2));
        chk(int'(backlog) == m_pend, "R3 backlog", int'(backlog), m_pend);
        chk(int'(energy_acc) == m_en, "R8 energy", int'(energy_acc), m_en);
        chk(int'(latency_acc) == m_lat, "R9 latency", int'(latency_acc), m_lat);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = 1'b0; tick = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = 0; m_pend = 0; m_idle = 0; m_ph = 0; m_en = 0; m_lat = 0;
        chk(dev_state == 2'd0, "R1 state", int'(dev_state), 0);
        chk(backlog == '0, "R1 backlog", int'(backlog), 0);
        chk(energy_acc == '0, "R1 energy", int'(energy_acc), 0);
        chk(latency_acc == '0, "R1 latency", int'(latency_acc), 0);
    endtask

    task automatic step(input bit r, input bit t);
        int pol;
        bit srv;
        bit has;
        int np;
        @(negedge clk);
        req = r; tick = t;
        @(posedge clk);
        pol = (policy == 2'd3) ? 2 : int'(policy);
        has = (m_pend > 0);
        srv = t && (m_st == 2) && has;
        np  = m_pend;
        if (r && !srv && m_pend < PMAX) np = m_pend + 1;
        else if (srv && !r) np = m_pend - 1;
        if (t) begin
            m_lat = (m_lat + m_pend > LMAX) ? LMAX : m_lat + m_pend;
            m_en  = (m_en + cost(m_st) > EMAX) ? EMAX : m_en + cost(m_st);
            case (m_st)
                0: begin
                    m_ph = 0;
                    if (pol == 0 || has) m_st = 1;
                end
                1: begin
                    if (m_ph == 1) begin m_st = 2; m_ph = 0; m_idle = 0; end
                    else m_ph = m_ph + 1;
                end
                2: begin
                    if (has || r) m_idle = 0;
                    else if (pol != 0) begin
                        if (pol == 1 || m_idle == int'(idle_limit)) begin
                            m_st = 3; m_ph = 0; m_idle = 0;
                        end else m_idle = m_idle + 1;
                    end
                end
                default: begin
                    m_ph = 0;
                    m_st = (pol == 0 || has) ? 1 : 0;
                end
            endcase
        end
        m_pend = np;
        #1;
        compare_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R5 greedy: single request, full cycle with hand-computed totals
        policy = 2'd1;
        step(1, 1);
        chk(dev_state == 2'd0, "R5 still off on arrival tick", int'(dev_state), 0);
        step(0, 1);
        chk(dev_state == 2'd1, "R5 wake on pending", int'(dev_state), 1);
        step(0, 1);
        step(0, 1);
        chk(dev_state == 2'd2 && energy_acc == 10'd40, "R2 wake lasts 2 ticks, R8 costs 40",
            int'(energy_acc), 40);
        step(0, 1);
        chk(backlog == '0, "R3 one served", int'(backlog), 0);
        step(0, 1);
        chk(dev_state == 2'd3, "R5 sleep when idle", int'(dev_state), 3);
        step(0, 1);
        chk(dev_state == 2'd0, "R2 sleep lasts 1 tick", int'(dev_state), 0);
        chk(energy_acc == 10'd70, "R8 total cycle energy", int'(energy_acc), 70);
        chk(latency_acc == 8'd4, "R9 request-ticks", int'(latency_acc), 4);

        // R7: request during shutdown wakes directly
        step(1, 1);
        step(0, 1);
        step(0, 1);
        step(0, 1);
        step(0, 1);
        step(0, 1);
        chk(dev_state == 2'd3, "R7 entered sleep", int'(dev_state), 3);
        step(1, 0);
        chk(dev_state == 2'd3, "R2 no tick no move", int'(dev_state), 3);
        step(0, 1);
        chk(dev_state == 2'd1, "R7 sleep to wake direct", int'(dev_state), 1);

        // R4 always powered
        do_reset();
        policy = 2'd0;
        step(0, 1);
        chk(dev_state == 2'd1, "R4 wake with no work", int'(dev_state), 1);
        step(0, 1);
        step(0, 1);
        for (int i = 0; i < 6; i++) step(0, 1);
        chk(dev_state == 2'd2, "R4 holds on", int'(dev_state), 2);

        // R6 timeout limit 3
        do_reset();
        policy = 2'd2;
        idle_limit = 4'd3;
        step(1, 1);
        step(0, 1);
        step(0, 1);
        step(0, 1);
        step(0, 1);
        step(0, 1);
        step(0, 1);
        step(0, 1);
        chk(dev_state == 2'd2, "R6 on after 3 idle ticks", int'(dev_state), 2);
        step(1, 1);
        chk(dev_state == 2'd2, "R6 req restarts count", int'(dev_state), 2);
        step(0, 1);
        for (int i = 0; i < 3; i++) step(0, 1);
        chk(dev_state == 2'd2, "R6 on before limit", int'(dev_state), 2);
        step(0, 1);
        chk(dev_state == 2'd3, "R6 sleep at limit", int'(dev_state), 3);

        // R3 saturation while off (no ticks)
        do_reset();
        policy = 2'd1;
        for (int i = 0; i < 10; i++) step(1, 0);
        chk(backlog == 3'd7, "R3 backlog saturates", int'(backlog), 7);

        // Sweep all policies and several limits with pseudo-random traffic
        for (int p = 0; p < 4; p++) begin
            for (int l = 0; l < 4; l++) begin
                do_reset();
                policy = 2'(p);
                idle_limit = TO_W'(l * 2);
                for (int k = 0; k < 150; k++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    step(int'(lfsr[3:0]) < (l * 3 + 2), lfsr[5:4] != 2'b00);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule